// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper with Optional Motor Output

This block sits between a CPU bus and the memories of a plug-in cartridge. It watches bus writes into the ROM address space and turns them into control state. That state is a 9-bit ROM bank number, a 4-bit external RAM bank number and a RAM enable. From the state and the current bus address it forms a 23-bit banked ROM address and a 17-bit banked RAM address, which go to the memory devices outside the block.

The ROM bank number is written in two parts. Its low byte and its top bit each have their own write window, so software can change one part without touching the other. Bank 0 is not remapped: it can be mapped into the switchable window like any other bank.

A parameter selects a variant in which one bit of the RAM bank write drives a vibration motor output. In that variant the bit is removed from the RAM bank number. The memories and any analog motor driver lie outside this block.

Top module: `cart_bank_mapper`

## Requirements
- R1: Asserting the reset gives ROM bank 1, RAM bank 0, RAM disabled and the motor output low.
- R2: A write with addr[15:12] equal to 0x0 or 0x1 sets the RAM enable when the data is 0x0A and clears it when the data is 0x00. Any other data leaves the enable as it was.
- R3: A write with addr[15:12] equal to 0x2 loads ROM bank bits [7:0] from the data byte and keeps bank bit 8.
- R4: A write with addr[15:12] equal to 0x3 loads ROM bank bit 8 from data bit 0 and keeps bank bits [7:0].
- R5: A ROM bank value of 0 is used exactly as written, with no substitution.
- R6: A write with addr[15:12] equal to 0x4 or 0x5 loads the RAM bank from data bits [3:0].
- R7: With RUMBLE_EN=1, a RAM bank write copies data bit 3 to the motor output, and RAM bank bit 3 is loaded as 0. With RUMBLE_EN=0, the motor output stays low and all four data bits go into the RAM bank.
- R8: A write with addr[15:12] in the range 0x6 to 0xF changes no bank, enable or motor state.
- R9: rom_addr is {rom_bank, addr[13:0]} when addr[15:14]=01, and {9'b0, addr[13:0]} when addr[15:14]=00.
- R10: ram_addr is {ram_bank, addr[12:0]}, and ram_en shows the current RAM enable.
- R11: The state changes only on a clock edge with wr_en high. An address and data held with wr_en low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Bus write strobe, sampled on the rising clock edge |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Bus write data |
| rom_addr | output | 23 | Banked ROM address |
| ram_addr | output | 17 | Banked external RAM address |
| ram_en | output | 1 | External RAM enable |
| motor_on | output | 1 | Motor drive (always low when RUMBLE_EN=0) |

## Verification
The hardest case is a partial update. A write to one part of the ROM bank must leave the other part untouched. The outputs can only show this once both the low byte and bit 8 hold values that differ from their reset state.

The stimulus table therefore builds the bank up in steps: 0x000, 0x100, 0x1A7, 0x0A7, 0x1A7 and 0x1FF. Each step writes only one window, and every step is read back through the upper ROM window. Both variants see the same bus traffic at the same time, so the diversion of the motor bit is checked against the plain variant on identical writes.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  typedef enum logic [2:0] {
    WIN_NONE     = 3'd0,
    WIN_RAM_GATE = 3'd1,
    WIN_BANK_LO  = 3'd2,
    WIN_BANK_HI  = 3'd3,
    WIN_RAM_SEL  = 3'd4
  } win_e;

  localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
  localparam logic [7:0] RAM_OFF_CODE = 8'h00;

endpackage

// File: rtl/cart_map_rst_sync.sv
module cart_map_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/cart_map_decode.sv
module cart_map_decode
  import cart_map_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win
);

  localparam int SEL_LSB = ADDR_W - 4;

  logic [3:0] sel;
  assign sel = addr[ADDR_W-1:SEL_LSB];

  always_comb begin
    unique case (sel)
      4'h0, 4'h1: win = WIN_RAM_GATE;
      4'h2:       win = WIN_BANK_LO;
      4'h3:       win = WIN_BANK_HI;
      4'h4, 4'h5: win = WIN_RAM_SEL;
      default:    win = WIN_NONE;
    endcase
  end

endmodule

// File: rtl/cart_map_regs.sv
module cart_map_regs
  import cart_map_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RAM_BANK_W = 4,
  parameter int MOTOR_BIT  = 3,
  parameter bit RUMBLE_EN  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  win_e                  win,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W:0]       rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_gate,
  output logic                  motor
);

  localparam int ROM_BANK_W = DATA_W + 1;
  localparam logic [ROM_BANK_W-1:0] ROM_BANK_RST = ROM_BANK_W'(1);

  logic [ROM_BANK_W-1:0] rom_q, rom_d;
  logic [RAM_BANK_W-1:0] ram_q, ram_d;
  logic                  gate_q, gate_d;
  logic [RAM_BANK_W-1:0] ram_src;
  logic                  ce;

  // clock enable: only a strobed write into a decoded window moves state
  assign ce = wr_en && (win != WIN_NONE);

  always_comb begin
    rom_d  = rom_q;
    ram_d  = ram_q;
    gate_d = gate_q;
    unique case (win)
      WIN_RAM_GATE: begin
        if (wdata == RAM_ON_CODE) begin
          gate_d = 1'b1;
        end else if (wdata == RAM_OFF_CODE) begin
          gate_d = 1'b0;
        end
      end
      WIN_BANK_LO: rom_d[DATA_W-1:0] = wdata;
      WIN_BANK_HI: rom_d[DATA_W]     = wdata[0];
      WIN_RAM_SEL: ram_d             = ram_src;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_q  <= ROM_BANK_RST;
      ram_q  <= '0;
      gate_q <= 1'b0;
    end else if (ce) begin
      rom_q  <= rom_d;
      ram_q  <= ram_d;
      gate_q <= gate_d;
    end
  end

  generate
    if (RUMBLE_EN) begin : g_motor
      logic motor_q, motor_d, motor_ce;

      always_comb begin
        ram_src            = wdata[RAM_BANK_W-1:0];
        ram_src[MOTOR_BIT] = 1'b0;
      end

      assign motor_ce = wr_en && (win == WIN_RAM_SEL);
      assign motor_d  = wdata[MOTOR_BIT];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          motor_q <= 1'b0;
        end else if (motor_ce) begin
          motor_q <= motor_d;
        end
      end

      assign motor = motor_q;

      // R7: the motor follows the diverted bit and the bank loses it
      a_r7_motor_divert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win == WIN_RAM_SEL) |=>
          (motor == $past(wdata[MOTOR_BIT])) && !ram_bank[MOTOR_BIT]);
    end else begin : g_plain
      assign ram_src = wdata[RAM_BANK_W-1:0];
      assign motor   = 1'b0;

      // R6: all four data bits land in the RAM bank
      a_r6_ram_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win == WIN_RAM_SEL) |=> ram_bank == $past(wdata[RAM_BANK_W-1:0]));
    end
  endgenerate

  assign rom_bank = rom_q;
  assign ram_bank = ram_q;
  assign ram_gate = gate_q;

  // R2: unknown codes leave the enable as it was
  a_r2_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == WIN_RAM_GATE && wdata != RAM_ON_CODE && wdata != RAM_OFF_CODE)
      |=> $stable(ram_gate));

  // R2: the on code opens the RAM
  a_r2_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == WIN_RAM_GATE && wdata == RAM_ON_CODE) |=> ram_gate);

  // R3: low byte loaded, top bit kept
  a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == WIN_BANK_LO) |=>
      (rom_bank[DATA_W-1:0] == $past(wdata)) && $stable(rom_bank[DATA_W]));

  // R4: top bit loaded, low byte kept
  a_r4_high_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win == WIN_BANK_HI) |=>
      (rom_bank[DATA_W] == $past(wdata[0])) && $stable(rom_bank[DATA_W-1:0]));

  // R8 / R11: no strobed write into a window leaves all state untouched
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && win != WIN_NONE) |=>
      $stable(rom_bank) && $stable(ram_bank) && $stable(ram_gate) && $stable(motor));

endmodule

// File: rtl/cart_map_addr.sv
module cart_map_addr #(
  parameter int ADDR_W     = 16,
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [ROM_BANK_W-1:0]               rom_bank,
  input  logic [RAM_BANK_W-1:0]               ram_bank,
  output logic [ROM_BANK_W+ADDR_W-3:0]        rom_addr,
  output logic [RAM_BANK_W+ADDR_W-4:0]        ram_addr
);

  localparam int ROM_OFS_W = ADDR_W - 2;
  localparam int RAM_OFS_W = ADDR_W - 3;

  logic                  upper_win;
  logic [ROM_BANK_W-1:0] eff_bank;

  assign upper_win = (addr[ADDR_W-1:ROM_OFS_W] == 2'b01);
  assign eff_bank  = upper_win ? rom_bank : '0;
  assign rom_addr  = {eff_bank, addr[ROM_OFS_W-1:0]};
  assign ram_addr  = {ram_bank, addr[RAM_OFS_W-1:0]};

  // R9: the fixed window never carries a bank number
  a_r9_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:ROM_OFS_W] == 2'b00) |->
      (rom_addr[ROM_BANK_W+ROM_OFS_W-1:ROM_OFS_W] == '0));

  // R10: RAM offset passes straight through
  a_r10_ram_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    ram_addr[RAM_OFS_W-1:0] == addr[RAM_OFS_W-1:0]);

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RAM_BANK_W = 4,
  parameter int MOTOR_BIT  = 3,
  parameter bit RUMBLE_EN  = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W+ADDR_W-2:0]     rom_addr,
  output logic [RAM_BANK_W+ADDR_W-4:0] ram_addr,
  output logic                         ram_en,
  output logic                         motor_on
);

  localparam int ROM_BANK_W = DATA_W + 1;

  logic                  rst_sync_n;
  win_e                  win;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;

  cart_map_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cart_map_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .win  (win)
  );

  cart_map_regs #(
    .DATA_W     (DATA_W),
    .RAM_BANK_W (RAM_BANK_W),
    .MOTOR_BIT  (MOTOR_BIT),
    .RUMBLE_EN  (RUMBLE_EN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .win      (win),
    .wdata    (wdata),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ram_gate (ram_en),
    .motor    (motor_on)
  );

  cart_map_addr #(
    .ADDR_W     (ADDR_W),
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (addr),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .rom_addr (rom_addr),
    .ram_addr (ram_addr)
  );

endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [22:0] rom_addr, rom_addr_p;
  logic [16:0] ram_addr, ram_addr_p;
  logic        ram_en, ram_en_p, motor_on, motor_on_p;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cart_bank_mapper #(.RUMBLE_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_en(ram_en), .motor_on(motor_on)
  );

  cart_bank_mapper #(.RUMBLE_EN(1'b0)) uut_plain (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rom_addr(rom_addr_p), .ram_addr(ram_addr_p), .ram_en(ram_en_p), .motor_on(motor_on_p)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
    logic [8:0]  rom;
    logic [3:0]  ram;
    logic [3:0]  ram_p;
    logic        en;
    logic        mot;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{16'h0000, 8'h0A, 9'h001, 4'h0, 4'h0, 1'b1, 1'b0}, // R2 enable on
    '{16'h1FFF, 8'h55, 9'h001, 4'h0, 4'h0, 1'b1, 1'b0}, // R2 unknown code holds
    '{16'h2000, 8'h00, 9'h000, 4'h0, 4'h0, 1'b1, 1'b0}, // R5 bank zero as written
    '{16'h3000, 8'h01, 9'h100, 4'h0, 4'h0, 1'b1, 1'b0}, // R4 top bit set
    '{16'h2123, 8'hA7, 9'h1A7, 4'h0, 4'h0, 1'b1, 1'b0}, // R3 low byte, top kept
    '{16'h3FFF, 8'hFE, 9'h0A7, 4'h0, 4'h0, 1'b1, 1'b0}, // R4 only bit 0 used
    '{16'h4000, 8'h0F, 9'h0A7, 4'h7, 4'hF, 1'b1, 1'b1}, // R6 R7 motor on
    '{16'h5555, 8'h05, 9'h0A7, 4'h5, 4'h5, 1'b1, 1'b0}, // R6 R7 motor off
    '{16'h6000, 8'hFF, 9'h0A7, 4'h5, 4'h5, 1'b1, 1'b0}, // R8 ignored
    '{16'h7ABC, 8'h00, 9'h0A7, 4'h5, 4'h5, 1'b1, 1'b0}, // R8 ignored
    '{16'h1000, 8'h00, 9'h0A7, 4'h5, 4'h5, 1'b0, 1'b0}, // R2 disable
    '{16'hA000, 8'h0A, 9'h0A7, 4'h5, 4'h5, 1'b0, 1'b0}, // R8 RAM region write
    '{16'h3000, 8'hFF, 9'h1A7, 4'h5, 4'h5, 1'b0, 1'b0}, // R4 top bit, low kept
    '{16'h2000, 8'hFF, 9'h1FF, 4'h5, 4'h5, 1'b0, 1'b0}  // R3 highest bank
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // observe state through the read paths; called right after a negedge
  task automatic observe(input string tag, input logic [8:0] rom, input logic [3:0] ram,
                         input logic [3:0] ram_p, input logic en, input logic mot);
    addr = 16'h5ABC; #1;
    chk({tag, " R9 R3 R4 R5 upper rom"}, 32'(rom_addr), 32'({rom, 14'h1ABC}));
    addr = 16'h1234; #1;
    chk({tag, " R9 fixed rom"}, 32'(rom_addr), 32'({9'h000, 14'h1234}));
    addr = 16'hB123; #1;
    chk({tag, " R10 R6 ram addr"}, 32'(ram_addr), 32'({ram, 13'h1123}));
    chk({tag, " R7 plain ram addr"}, 32'(ram_addr_p), 32'({ram_p, 13'h1123}));
    chk({tag, " R2 R10 ram_en"}, 32'(ram_en), 32'(en));
    chk({tag, " R7 motor"}, 32'(motor_on), 32'(mot));
    chk({tag, " R7 plain motor"}, 32'(motor_on_p), 32'(1'b0));
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wr_en = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    observe("R1 reset", 9'h001, 4'h0, 4'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    observe("R1 after release", 9'h001, 4'h0, 4'h0, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i].a, VEC[i].d);
      observe($sformatf("vec %0d", i), VEC[i].rom, VEC[i].ram, VEC[i].ram_p,
              VEC[i].en, VEC[i].mot);
    end

    // R11: window addresses with the strobe low change nothing
    @(negedge clk);
    addr = 16'h2000; wdata = 8'h33; wr_en = 1'b0;
    @(negedge clk);
    addr = 16'h0000; wdata = 8'h0A;
    @(negedge clk);
    addr = 16'h4000; wdata = 8'h0E;
    @(negedge clk);
    observe("R11 no strobe", 9'h1FF, 4'h5, 4'h5, 1'b0, 1'b0);

    // R7: motor bit set with other bits clear
    bus_write(16'h4FFF, 8'h08);
    observe("R7 motor only", 9'h1FF, 4'h0, 4'h8, 1'b0, 1'b1);

    // R1: reset in mid-run restores the reset state at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    observe("R1 mid-run reset", 9'h001, 4'h0, 4'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(16'h2000, 8'h42);
    observe("R3 after reset", 9'h042, 4'h0, 4'h0, 1'b0, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule